// File: doc/BRIEF.md
# Single-Wire Debug Link Target Interface

This block is the target end of a two-way serial debug link that runs over one shared line. The line has a pull-up and open-drain drivers, so any party may pull it low and nobody drives it high. The host begins every bit by pulling the line low. When the target receives, it reads the level part-way through the bit. When the target sends, it stretches the host's low pulse to a short or a long length to signal a 1 or a 0. Bytes travel most significant bit first, and one bit lasts 16 debug-clock cycles.

Received bytes go to a command decoder as a byte with a one-clock strobe. The decoder hands back bytes to send, and it reports when a command has finished so that the block can send an acknowledge pulse if handshaking is on. If the host holds the line low for a long time, the block replies with a fixed-length low reference pulse. The host measures that pulse to learn the link speed. The debug clock is either the system clock itself or a slower clock-enable strobe, selected by one input.

Top module: `swd_link`

## Requirements
- R1: A falling edge on `pin_in` while the link is idle starts a 16-debug-cycle bit, with the edge cycle counted as cycle 0. The level at cycle 10 is the bit value: low is 0 and high is 1. Eight such bits, most significant first, form `rx_byte`, which is presented with a one-clock `rx_valid` pulse.
- R2: `rx_valid` pulses only for bytes the host writes. It stays low while a byte is being sent to the host.
- R3: A `tx_load` pulse while idle captures `tx_byte` and raises `tx_busy`. Each following host falling edge sends one bit, most significant first. The line is kept low for 4 debug cycles for a 1 and 13 debug cycles for a 0, counted from the edge cycle, and is then released. `tx_busy` falls after the eighth bit.
- R4: The block only ever pulls the line low through `pin_drive_low`. After reset the line is released.
- R5: If the line has been low for at least 128 debug cycles, the block waits after the host releases it. Counting the release cycle, the line stays high for 17 debug cycles. The block then drives it low for exactly 128 debug cycles and pulses `sync_det` once. A low shorter than 128 cycles produces no reply.
- R6: If the line is still low at the last cycle of a bit, any partly received byte is discarded. The next complete byte is received intact.
- R7: When `cmd_done` pulses with `ack_en` high, the block drives a low pulse 16 debug cycles long. With `ack_en` low, `cmd_done` produces no pulse.
- R8: With `clk_sel` high, every clock is a debug cycle. With `clk_sel` low, only clocks with `alt_tick` high are debug cycles. All timing above counts debug cycles.
- R9: After reset, `rx_valid`, `tx_busy`, `sync_det` and `pin_drive_low` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_sel | input | 1 | 1: debug cycle on every clock; 0: debug cycle on `alt_tick` |
| alt_tick | input | 1 | Clock-enable strobe of the alternative debug clock |
| pin_in | input | 1 | Synchronized level of the shared line |
| pin_drive_low | output | 1 | Enables the open-drain pull-down |
| rx_byte | output | 8 | Last byte received from the host |
| rx_valid | output | 1 | One-clock strobe for `rx_byte` |
| tx_byte | input | 8 | Byte to send to the host |
| tx_load | input | 1 | Captures `tx_byte` while idle |
| tx_busy | output | 1 | High while a loaded byte is being sent |
| ack_en | input | 1 | Handshake enable |
| cmd_done | input | 1 | Command-finished pulse from the decoder |
| sync_det | output | 1 | One-clock pulse when a reference pulse is scheduled |

## Verification
The assertions check several rules on every cycle. The state never advances without a debug cycle. A reference pulse is only scheduled after the low-time counter has saturated. An acknowledge starts only from a pending request that arrived with handshaking enabled. Receive strobes only follow a received bit. Pulse lengths on the line, bit order, how bytes assemble, the discarding of a partial byte, and the scaling of all timing under the alternative clock are shown only by the bench's scenarios. In those scenarios the bench plays the host and measures the line.

// File: rtl/swd_link.sv
module swd_link #(
  parameter int BIT_T     = 16,
  parameter int SAMPLE_AT = 10,
  parameter int ONE_LOW   = 4,
  parameter int ZERO_LOW  = 13,
  parameter int SYNC_MIN  = 128,
  parameter int SYNC_GAP  = 16,
  parameter int SYNC_LEN  = 128,
  parameter int ACK_LEN   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_sel,
  input  logic       alt_tick,
  input  logic       pin_in,
  output logic       pin_drive_low,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  input  logic [7:0] tx_byte,
  input  logic       tx_load,
  output logic       tx_busy,
  input  logic       ack_en,
  input  logic       cmd_done,
  output logic       sync_det
);
  localparam int CW = $clog2(SYNC_LEN + SYNC_GAP + BIT_T + ACK_LEN + 1);
  localparam int LW = $clog2(SYNC_MIN + 1);

  typedef enum logic [2:0] {S_IDLE, S_BIT, S_WAITH, S_SGAP, S_SREP, S_ACK} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [LW-1:0] low_run;
  logic [2:0]    bitcnt;
  logic [7:0]    rx_sh, tx_sh;
  logic          prev, tx_mode, ack_pend;
  logic          tick;
  logic [CW-1:0] hold;

  assign tick    = clk_sel | alt_tick;
  assign tx_busy = tx_mode;
  assign hold    = tx_sh[7] ? CW'(ONE_LOW) : CW'(ZERO_LOW);
  assign pin_drive_low = (state == S_BIT && tx_mode && cnt < hold) ||
                         state == S_ACK || state == S_SREP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      low_run  <= '0;
      bitcnt   <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      sync_det <= 1'b0;
      prev     <= 1'b1;
      tx_mode  <= 1'b0;
      ack_pend <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      sync_det <= 1'b0;
      if (cmd_done && ack_en) ack_pend <= 1'b1;
      if (tx_load && !tx_mode && state == S_IDLE) begin
        tx_mode <= 1'b1;
        tx_sh   <= tx_byte;
        bitcnt  <= '0;
      end
      if (tick) begin
        prev <= pin_in;
        if (pin_in) low_run <= '0;
        else if (!pin_drive_low && low_run != LW'(SYNC_MIN)) low_run <= low_run + 1'b1;
        case (state)
          S_IDLE: begin
            if (prev && !pin_in) begin
              state <= S_BIT;
              cnt   <= CW'(1);
            end else if (ack_pend) begin
              state    <= S_ACK;
              cnt      <= '0;
              ack_pend <= 1'b0;
            end
          end
          S_BIT: begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(SAMPLE_AT) && !tx_mode) rx_sh <= {rx_sh[6:0], pin_in};
            if (cnt == CW'(BIT_T - 1)) begin
              if (!pin_in) begin
                state   <= S_WAITH;
                bitcnt  <= '0;
                tx_mode <= 1'b0;
              end else begin
                state  <= S_IDLE;
                bitcnt <= bitcnt + 1'b1;
                if (tx_mode) begin
                  tx_sh <= {tx_sh[6:0], 1'b0};
                  if (bitcnt == 3'd7) tx_mode <= 1'b0;
                end else if (bitcnt == 3'd7) begin
                  rx_byte  <= rx_sh;
                  rx_valid <= 1'b1;
                end
              end
            end
          end
          S_WAITH: begin
            if (pin_in) begin
              if (low_run == LW'(SYNC_MIN)) begin
                state    <= S_SGAP;
                cnt      <= '0;
                sync_det <= 1'b1;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_SGAP: begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(SYNC_GAP - 1)) begin
              state <= S_SREP;
              cnt   <= '0;
            end
          end
          S_SREP: begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(SYNC_LEN - 1)) state <= S_IDLE;
          end
          S_ACK: begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(ACK_LEN - 1)) state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assert_state_waits_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(state));

  assert_sync_after_long_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SGAP && $past(state) == S_WAITH) |-> $past(low_run) == LW'(SYNC_MIN));

  assert_ack_from_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACK && $past(state) != S_ACK) |-> $past(ack_pend));

  assert_request_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_pend) |-> $past(cmd_done && ack_en));

  assert_strobe_from_rx_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(state) == S_BIT && !$past(tx_mode)));

  assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

// File: tb/swd_link_tb_top.sv
module swd_link_tb_top;
  logic clk = 0, rst_n = 0;
  logic clk_sel = 1, host_low = 0, tx_load = 0, ack_en = 0, cmd_done = 0;
  logic [7:0] tx_byte = 0;
  logic [1:0] divc = 0;
  logic alt_tick, wire_lvl, pin_drive_low, rx_valid, tx_busy, sync_det;
  logic [7:0] rx_byte;
  int total = 0, bad = 0, sync_cnt = 0;
  logic [7:0] exp_q[$];
  logic drive_seen = 0, writing = 0;

  always #5 clk = ~clk;
  always @(posedge clk) divc <= (divc == 2) ? 2'd0 : divc + 2'd1;
  assign alt_tick = (divc == 0);
  assign wire_lvl = ~(host_low | pin_drive_low);

  swd_link dut_i (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .alt_tick(alt_tick),
    .pin_in(wire_lvl), .pin_drive_low(pin_drive_low), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .tx_byte(tx_byte), .tx_load(tx_load), .tx_busy(tx_busy),
    .ack_en(ack_en), .cmd_done(cmd_done), .sync_det(sync_det));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (sync_det) sync_cnt++;
    if (writing && pin_drive_low) drive_seen = 1;
    if (rx_valid) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected rx_valid", rx_byte, -1);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rx_byte == e, "R1 received byte", rx_byte, e);
      end
    end
  end

  task automatic dstep();
    do @(negedge clk); while (!(clk_sel || divc == 0));
  endtask

  task automatic host_bit(input bit b);
    for (int k = 0; k < 16; k++) begin
      dstep();
      host_low = (k < (b ? 4 : 13));
    end
  endtask

  task automatic host_write(input logic [7:0] b);
    exp_q.push_back(b);
    writing = 1; drive_seen = 0;
    for (int i = 7; i >= 0; i--) host_bit(b[i]);
    dstep(); dstep();
    writing = 0;
    chk(!drive_seen, "R4 no drive while host writes", drive_seen, 0);
  endtask

  task automatic host_read(input logic [7:0] expb);
    logic [7:0] got = 0;
    @(negedge clk); tx_byte = expb; tx_load = 1;
    @(negedge clk); tx_load = 0;
    chk(tx_busy, "R3 tx_busy after load", tx_busy, 1);
    for (int i = 7; i >= 0; i--) begin
      int lc = 0;
      for (int k = 0; k < 16; k++) begin
        dstep();
        host_low = (k == 0);
        #1;
        if (!wire_lvl) lc++;
        if (k == 10) got = {got[6:0], wire_lvl};
      end
      chk(lc == (expb[i] ? 4 : 13), "R3 low length per bit", lc, expb[i] ? 4 : 13);
    end
    dstep(); dstep();
    chk(got == expb, "R3 byte sent MSB first", got, expb);
    chk(!tx_busy, "R3 tx_busy falls after 8 bits", tx_busy, 0);
  endtask

  task automatic ack_len(output int n);
    n = 0;
    @(negedge clk); cmd_done = 1;
    @(negedge clk); cmd_done = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (!wire_lvl) n++;
    end
  endtask

  task automatic long_low(input int n, output int gap, output int len);
    for (int k = 0; k < n; k++) begin dstep(); host_low = 1; end
    gap = 0; len = 0;
    dstep(); host_low = 0; #1;
    while (wire_lvl && gap < 300) begin gap++; dstep(); #1; end
    while (!wire_lvl && len < 300) begin len++; dstep(); #1; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, g, l, s0;
    #1;
    chk(!pin_drive_low && !rx_valid && !tx_busy && !sync_det, "R9 reset state",
        {pin_drive_low, rx_valid, tx_busy, sync_det}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!pin_drive_low && !tx_busy, "R4 released after reset", pin_drive_low, 0);

    host_write(8'hA5);
    host_write(8'h00);
    host_write(8'hFF);
    host_write(8'h3C);

    host_read(8'hC3);
    host_read(8'h01);

    ack_en = 1; ack_len(n);
    chk(n == 16, "R7 ack pulse length", n, 16);
    ack_en = 0; ack_len(n);
    chk(n == 0, "R7 no ack when disabled", n, 0);

    s0 = sync_cnt;
    long_low(130, g, l);
    chk(g == 17, "R5 gap before reference pulse", g, 17);
    chk(l == 128, "R5 reference pulse length", l, 128);
    chk(sync_cnt == s0 + 1, "R5 sync_det pulse", sync_cnt - s0, 1);

    s0 = sync_cnt;
    for (int k = 0; k < 60; k++) begin dstep(); host_low = 1; end
    dstep(); host_low = 0;
    n = 0;
    for (int k = 0; k < 200; k++) begin dstep(); #1; if (!wire_lvl) n++; end
    chk(n == 0 && sync_cnt == s0, "R5 short low gives no reply", n, 0);

    host_bit(1); host_bit(0); host_bit(1);
    for (int k = 0; k < 60; k++) begin dstep(); host_low = 1; end
    dstep(); host_low = 0;
    dstep(); dstep();
    host_write(8'h96);

    clk_sel = 0;
    host_write(8'h5A);
    ack_en = 1; ack_len(n);
    chk(n == 48, "R8 ack scales with alternative clock", n, 48);
    ack_en = 0;
    host_read(8'hB4);
    clk_sel = 1;

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all expected bytes received", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule